// File: doc/BRIEF.md
# Programmable Spreading Code Generator

This block spreads a serial transmit bit stream with a programmable chip sequence for a direct-sequence spread spectrum transmitter. A 16-bit code word is put together from two byte registers written over a small register write port. A 2-bit length field on the same port selects how many of the code bits form one code period. Each chip-enable pulse produces one output chip: the selected code bit XORed with the data bit currently being spread. A one-clock symbol strobe marks the last chip of every period, and the next data bit is captured on that strobe.

One chip stream drives both the in-phase and the quadrature outputs. Register writes go into shadow copies, which are moved into the working copies only at a period boundary or while transmission is disabled. A period in progress therefore always finishes with the code and length it started with. Pulling transmit enable low clears the outputs and rewinds the sequence to its first chip.

Top module: `dsss_spreader`

## Requirements
- R1: A write with `wr_sel`=00 loads code bits 7:0, `wr_sel`=01 loads code bits 15:8, and `wr_sel`=10 loads the length field from `wr_data[1:0]`. `wr_sel`=11 has no effect.
- R2: Length field encoding: 00 selects 11 chips, 01 selects 13, 10 selects 15 and 11 selects 16.
- R3: For a length of N, only code bits N-1 down to 0 are used. Bit N-1 is the first chip of a period and bit 0 is the last.
- R4: A clock edge with `tx_en` and `chip_en` both high sets `chip_i` to the current code bit XOR the current data bit. The value is visible after that edge.
- R5: `chip_q` always equals `chip_i`.
- R6: The chip position advances only on edges where `chip_en` is high. On other edges with `tx_en` high, the chip output holds and `sym_strobe` is 0.
- R7: `sym_strobe` is high for exactly one clock, after the edge that emits chip bit 0. `data_in` is captured on that edge and spreads the next period. While `tx_en` is low, `data_in` is captured on every edge.
- R8: Code and length writes made during a period take effect only from the next period. While `tx_en` is low, they take effect on the following clock edge.
- R9: After an edge with `tx_en` low, `chip_i`, `chip_q` and `sym_strobe` are 0. The next chip emitted is bit N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 low byte, 01 high byte, 10 length |
| wr_data | input | 8 | Write data |
| tx_en | input | 1 | Transmit enable |
| chip_en | input | 1 | Chip-rate enable pulse |
| data_in | input | 1 | Data bit to be spread |
| chip_i | output | 1 | Spread chip, in-phase path |
| chip_q | output | 1 | Spread chip, quadrature path |
| sym_strobe | output | 1 | Last-chip-of-period strobe |

## Verification
The bench uses the default 8-bit byte width, which gives a 16-bit code word. It sweeps every length code against several code words, including all-ones, a lone low bit and mixed patterns. Each setting runs over several data periods, so both polarities of the data XOR appear. The code words use the full register width, so bits above the selected length must stay unused; this exposes any wrong justification or bit ordering. Directed runs add gaps in the chip enable, a rewrite of code and length partway through a period, and a drop of transmit enable partway through a period.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_LO  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_HI  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_LEN = 2'b10;

  // chip count for a length field value
  function automatic int unsigned code_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 11;
      2'b01:   return 13;
      2'b10:   return 15;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/dsss_cfg_regs.sv
module dsss_cfg_regs
  import dsss_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load,
  output logic [1:0]        shd_len,
  output logic [CODE_W-1:0] act_code
);
  logic [BYTE_W-1:0] shd_lo, shd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_lo  <= '0;
      shd_hi  <= '0;
      shd_len <= 2'b11;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_LO:  shd_lo  <= wr_data;
        SEL_HI:  shd_hi  <= wr_data;
        SEL_LEN: shd_len <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_code <= '0;
    else if (load) act_code <= {shd_hi, shd_lo};
  end
endmodule

// File: rtl/dsss_chip_counter.sv
module dsss_chip_counter
  import dsss_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             chip_en,
  input  logic [1:0]       nxt_len,
  output logic [IDX_W-1:0] idx,
  output logic             period_end
);
  logic [IDX_W-1:0] first_idx;

  assign first_idx  = IDX_W'(code_len(nxt_len) - 1);
  assign period_end = tx_en && chip_en && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= first_idx;
    else if (!tx_en)     idx <= first_idx;
    else if (period_end) idx <= first_idx;
    else if (chip_en)    idx <= idx - 1'b1;
  end
endmodule

// File: rtl/dsss_chip_out.sv
module dsss_chip_out #(
  parameter int CODE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              chip_en,
  input  logic              data_in,
  input  logic              period_end,
  input  logic [CODE_W-1:0] act_code,
  input  logic [IDX_W-1:0]  idx,
  output logic              chip,
  output logic              strobe
);
  logic cur_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cur_data <= 1'b0;
    else if (!tx_en || period_end)    cur_data <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip   <= 1'b0;
      strobe <= 1'b0;
    end else if (!tx_en) begin
      chip   <= 1'b0;
      strobe <= 1'b0;
    end else if (chip_en) begin
      chip   <= act_code[idx] ^ cur_data;
      strobe <= period_end;
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = 2 * BYTE_W,
  localparam int IDX_W  = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              chip_en,
  input  logic              data_in,
  output logic              chip_i,
  output logic              chip_q,
  output logic              sym_strobe
);
  logic [1:0]        shd_len;
  logic [CODE_W-1:0] act_code;
  logic [IDX_W-1:0]  idx;
  logic              period_end;
  logic              cfg_load;
  logic              chip;

  assign cfg_load = !tx_en || period_end;

  dsss_cfg_regs #(.BYTE_W(BYTE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .load(cfg_load), .shd_len(shd_len), .act_code(act_code)
  );

  dsss_chip_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .chip_en(chip_en),
    .nxt_len(shd_len), .idx(idx), .period_end(period_end)
  );

  dsss_chip_out #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .chip_en(chip_en),
    .data_in(data_in), .period_end(period_end), .act_code(act_code),
    .idx(idx), .chip(chip), .strobe(sym_strobe)
  );

  assign chip_i = chip;
  assign chip_q = chip;
endmodule

// File: rtl/dsss_spreader_chk.sv
module dsss_spreader_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              chip_en,
  input logic              chip_i,
  input logic              chip_q,
  input logic              sym_strobe,
  input logic              period_end,
  input logic [CODE_W-1:0] act_code
);
  // R5
  iq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_i == chip_q);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> !sym_strobe);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!chip_i && !sym_strobe));

  // R6
  hold_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !chip_en) |=> ($stable(chip_i) && !sym_strobe));

  // R8
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !period_end) |=> $stable(act_code));

  // R7
  strobe_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> sym_strobe);
endmodule

bind dsss_spreader dsss_spreader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .chip_en(chip_en),
  .chip_i(chip_i), .chip_q(chip_q), .sym_strobe(sym_strobe),
  .period_end(period_end), .act_code(act_code)
);

// File: tb/sim_dsss_spreader.sv
module sim_dsss_spreader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic tx_en = 1'b0, chip_en = 1'b0, data_in = 1'b0;
  logic chip_i, chip_q, sym_strobe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dsss_spreader u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tx_en(tx_en), .chip_en(chip_en), .data_in(data_in),
    .chip_i(chip_i), .chip_q(chip_q), .sym_strobe(sym_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nlen(input logic [1:0] s);
    return (s == 2'b11) ? 16 : 11 + 2 * int'(s);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] code, input logic [1:0] ls, input logic d0);
    @(negedge clk);
    tx_en = 1'b0; chip_en = 1'b0;
    wr(2'b00, code[7:0]);
    wr(2'b01, code[15:8]);
    wr(2'b10, {6'd0, ls});
    data_in = d0;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
  endtask

  // nch chips of a period; mid-period write of ncode/nls when wr_at>=0
  task automatic run(input logic [15:0] code, input logic [1:0] ls,
                     input logic dcur, input logic dnext, input int nch,
                     input bit gap, input int wr_at,
                     input logic [15:0] ncode, input logic [1:0] nls);
    int n = nlen(ls);
    for (int j = 0; j < nch; j++) begin
      @(negedge clk);
      chip_en = 1'b1; data_in = dnext;
      @(posedge clk); #1;
      chk("R3/R4 chip", int'(chip_i), int'(code[n-1-j] ^ dcur));
      chk("R5 iq", int'(chip_q), int'(chip_i));
      chk("R7 strobe", int'(sym_strobe), int'(j == n - 1));
      if (gap && j == 2) begin
        @(negedge clk);
        chip_en = 1'b0;
        @(posedge clk); #1;
        chk("R6 hold", int'(chip_i), int'(code[n-1-j] ^ dcur));
        chk("R6 no strobe", int'(sym_strobe), 0);
      end
      if (j == wr_at) begin
        @(negedge clk);
        chip_en = 1'b0;
        wr(2'b00, ncode[7:0]);
        wr(2'b01, ncode[15:8]);
        wr(2'b10, {6'd0, nls});
        wr(2'b11, 8'hFF);
      end
    end
    @(negedge clk);
    chip_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    logic [15:0] codes [4];
    logic dseq [5];
    codes[0] = 16'hA5C3; codes[1] = 16'h0001;
    codes[2] = 16'hFFFF; codes[3] = 16'h6B2E;
    dseq[0] = 1'b0; dseq[1] = 1'b1; dseq[2] = 1'b1; dseq[3] = 1'b0; dseq[4] = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset chip", int'(chip_i), 0);
    chk("reset strobe", int'(sym_strobe), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R7 sweep
    for (int l = 0; l < 4; l++) begin
      for (int c = 0; c < 4; c++) begin
        setup(codes[c], 2'(l), dseq[0]);
        for (int p = 0; p < 4; p++)
          run(codes[c], 2'(l), dseq[p], dseq[p+1], nlen(2'(l)), (p == 1), -1, 16'h0, 2'b0);
        tx_en = 1'b0;
        @(posedge clk); #1;
        chk("R9 idle chip", int'(chip_i), 0);
        chk("R9 idle strobe", int'(sym_strobe), 0);
      end
    end

    // R8 mid-period rewrite: old code finishes, new one next period
    setup(16'h9D37, 2'b11, 1'b1);
    run(16'h9D37, 2'b11, 1'b1, 1'b0, 16, 1'b0, 5, 16'h42F1, 2'b00);
    run(16'h42F1, 2'b00, 1'b0, 1'b1, 11, 1'b0, -1, 16'h0, 2'b0);

    // R9 drop of tx_en mid-period, restart at first chip
    setup(16'h3C5A, 2'b01, 1'b0);
    run(16'h3C5A, 2'b01, 1'b0, 1'b1, 5, 1'b0, -1, 16'h0, 2'b0);
    tx_en = 1'b0; data_in = 1'b1;
    @(posedge clk); #1;
    chk("R9 drop chip", int'(chip_i), 0);
    chk("R9 drop strobe", int'(sym_strobe), 0);
    @(negedge clk);
    tx_en = 1'b1;
    run(16'h3C5A, 2'b01, 1'b1, 1'b0, 13, 1'b0, -1, 16'h0, 2'b0);

    // R1 select 11 ignored: code stays after a write to it
    setup(16'h5A5A, 2'b10, 1'b0);
    wr(2'b11, 8'h00);
    run(16'h5A5A, 2'b10, 1'b0, 1'b0, 15, 1'b0, -1, 16'h0, 2'b0);
    finish_up();
  end
endmodule